// File: doc/BRIEF.md
# Qualified Event Counter

This block is one programmable performance-monitoring counter. Software loads a 32-bit setup word that picks an event (an 8-bit selector code plus an 8-bit lane mask) and sets how the per-cycle event count is qualified: privilege filtering, a choice between the local thread alone and the local thread plus a sibling thread, and an optional threshold. The threshold can be inverted, and it can be limited to rising edges. A 48-bit counter then advances, and software can read it or load it directly.

Each cycle the block sees two banks of single-bit event lanes, one from the local logical processor and one from its sibling, along with the current 2-bit privilege level. The lanes come in groups of eight. The selector code picks a group, and the lane mask picks which lanes of that group are summed. When the counter carries out of its top bit with the interrupt enable set, a sticky overflow flag is raised and drives the interrupt line. Software clears the flag by pulsing a write-one-to-clear input.

Top module: `evt_qual_counter`

## Requirements
- R1: After reset the counter, the setup word, the overflow flag and the interrupt output are all zero.
- R2: Setup word bits [7:0] are the selector code and bits [15:8] are the lane mask. Code bits [1:0] pick lane group g, and mask bit k selects lane bit g*8+k of the local lane input. The per-cycle count is the number of selected lanes that are set.
- R3: With the threshold field (setup bits [31:24]) at zero, the counter adds the full per-cycle count each cycle. The edge bit (18) and the invert bit (22) then have no effect.
- R4: With a nonzero threshold and invert clear, the counter adds one in each cycle whose per-cycle count is greater than or equal to the threshold, and nothing otherwise.
- R5: With a nonzero threshold and invert set, the counter adds one in each cycle whose per-cycle count is below the threshold.
- R6: With a nonzero threshold and edge set, the counter adds one only on a cycle where the threshold condition is true and was false in the previous cycle.
- R7: Setup bit 17 enables counting at privilege level 0, and bit 16 enables it at levels 1 to 3. With both bits clear, nothing is counted.
- R8: With setup bit 19 set, the selected lanes of the sibling input are added to the local count. With it clear, the sibling input is ignored.
- R9: With the enable bit (21) clear, the counter holds its value and the edge history is cleared. If the condition is already true when counting is re-enabled, the first enabled cycle counts as an edge.
- R10: A counter load takes effect on the next clock and wins over any count in that cycle. A setup write also takes effect on the next clock.
- R11: A carry out of bit 47 with the interrupt enable (bit 20) set sets the overflow flag and the interrupt output. Both stay set until cleared. A carry with the interrupt enable clear leaves the flag unchanged.
- R12: A pulse on the clear input clears the overflow flag on the next clock. If an overflow happens in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setup word write strobe |
| cfg_wdata | input | 32 | Setup word write data |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | 48 | Counter load value |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| priv_lvl | input | 2 | Current privilege level |
| loc_evt | input | 32 | Local thread event lanes, 4 groups of 8 |
| sib_evt | input | 32 | Sibling thread event lanes, 4 groups of 8 |
| cfg_q | output | 32 | Current setup word |
| cnt_q | output | 48 | Counter value |
| ovf_q | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of actions can land in the same cycle: a software load together with a nonzero event count, and an overflow carry together with a clear pulse. The bench drives a load while eight lanes are active and expects the loaded value rather than the loaded value plus eight; it then checks that the following cycle adds the eight. It also parks the counter at all ones and applies a single event together with a clear pulse while the flag is already set, and expects the flag to remain set; a clear pulse on its own must then drop both the flag and the interrupt.

// File: rtl/evt_qual_counter.sv
module evt_qual_counter #(
  parameter int CNT_W  = 48,
  parameter int LANES  = 8,
  parameter int GROUPS = 4,
  parameter int THR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [31:0]             cfg_wdata,
  input  logic                    cnt_we,
  input  logic [CNT_W-1:0]        cnt_wdata,
  input  logic                    ovf_clr,
  input  logic [1:0]              priv_lvl,
  input  logic [LANES*GROUPS-1:0] loc_evt,
  input  logic [LANES*GROUPS-1:0] sib_evt,
  output logic [31:0]             cfg_q,
  output logic [CNT_W-1:0]        cnt_q,
  output logic                    ovf_q,
  output logic                    irq
);
  localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int SUM_W  = $clog2(2*LANES + 1);

  function automatic logic [SUM_W-1:0] pop(input logic [LANES-1:0] v);
    logic [SUM_W-1:0] s;
    s = '0;
    for (int i = 0; i < LANES; i++) s = s + SUM_W'(v[i]);
    return s;
  endfunction

  logic [GSEL_W-1:0] gsel;
  logic [LANES-1:0]  mask, loc_sel, sib_sel;
  logic              usr_en, os_en, edge_en, any_en, ie, en, inv;
  logic [THR_W-1:0]  thr;

  assign gsel    = cfg_q[GSEL_W-1:0];
  assign mask    = cfg_q[8 +: LANES];
  assign usr_en  = cfg_q[16];
  assign os_en   = cfg_q[17];
  assign edge_en = cfg_q[18];
  assign any_en  = cfg_q[19];
  assign ie      = cfg_q[20];
  assign en      = cfg_q[21];
  assign inv     = cfg_q[22];
  assign thr     = cfg_q[24 +: THR_W];

  assign loc_sel = loc_evt[gsel*LANES +: LANES] & mask;
  assign sib_sel = sib_evt[gsel*LANES +: LANES] & mask;

  logic [SUM_W-1:0] raw;
  assign raw = pop(loc_sel) + (any_en ? pop(sib_sel) : '0);

  logic priv_ok, active, ge, cond, prev, thr_zero;
  assign priv_ok  = (priv_lvl == 2'd0) ? os_en : usr_en;
  assign active   = en & priv_ok;
  assign thr_zero = (thr == '0);
  assign ge       = ((THR_W+1)'(raw)) >= {1'b0, thr};
  assign cond     = active & (inv ? ~ge : ge);

  logic [SUM_W-1:0] inc;
  always_comb begin
    if (thr_zero)     inc = active ? raw : '0;
    else if (edge_en) inc = SUM_W'(cond & ~prev);
    else              inc = SUM_W'(cond);
  end

  logic [CNT_W:0] sum;
  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
      prev  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      prev  <= cond & ~thr_zero;
      cnt_q <= cnt_we ? cnt_wdata : sum[CNT_W-1:0];
      if (!cnt_we && sum[CNT_W] && ie) ovf_q <= 1'b1;
      else if (ovf_clr)                ovf_q <= 1'b0;
    end
  end

  assign irq = ovf_q;
endmodule

// File: rtl/evt_qual_counter_chk.sv
module evt_qual_counter_chk #(
  parameter int CNT_W   = 48,
  parameter int MAX_INC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             ovf_clr,
  input logic [31:0]      cfg_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_q
);
  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata));

  // R9
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[21] && !cnt_we) |=> $stable(cnt_q));

  // R7
  no_priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[17:16] == 2'b00 && !cnt_we) |=> $stable(cnt_q));

  // R3
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_q - $past(cnt_q)) <= CNT_W'(MAX_INC));

  // R6
  edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[18] && cfg_q[31:24] != 8'd0 && !cnt_we) |=> (cnt_q - $past(cnt_q)) <= CNT_W'(1));

  // R11
  ovf_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(cfg_q[20]));

  // R12
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !cfg_q[20]) |=> !ovf_q);
endmodule

bind evt_qual_counter evt_qual_counter_chk #(.CNT_W(CNT_W), .MAX_INC(2*LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .ovf_clr(ovf_clr), .cfg_q(cfg_q), .cnt_q(cnt_q), .ovf_q(ovf_q)
);

// File: tb/evt_qual_counter_bench.sv
`timescale 1ns/1ps
module evt_qual_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [47:0] cnt_wdata = '0;
  logic        ovf_clr = 1'b0;
  logic [1:0]  priv_lvl = '0;
  logic [31:0] loc_evt = '0;
  logic [31:0] sib_evt = '0;
  logic [31:0] cfg_q;
  logic [47:0] cnt_q;
  logic        ovf_q, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_qual_counter u_evt_qual_counter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
    .priv_lvl(priv_lvl), .loc_evt(loc_evt), .sib_evt(sib_evt),
    .cfg_q(cfg_q), .cnt_q(cnt_q), .ovf_q(ovf_q), .irq(irq)
  );

  function automatic logic [31:0] mkcfg(input logic [7:0] code, input logic [7:0] mask,
      input logic usr, input logic os, input logic edg, input logic any,
      input logic ie, input logic en, input logic inv, input logic [7:0] thr);
    return {thr, 1'b0, inv, en, ie, any, edg, os, usr, mask, code};
  endfunction

  typedef struct packed {
    logic [31:0] cfg;
    logic [1:0]  priv;
    logic [31:0] loc;
    logic [31:0] sib;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{mkcfg(8'd0, 8'hFF, 1, 1, 0, 0, 0, 1, 0, 8'd0), 2'd0, 32'h000000FF, 32'h0, 8'd8, 8'd2},  // R2
    '{mkcfg(8'd1, 8'h0F, 1, 1, 1, 0, 0, 1, 1, 8'd0), 2'd1, 32'h00FFFF00, 32'h0, 8'd4, 8'd3},  // R3
    '{mkcfg(8'd2, 8'hFF, 0, 1, 0, 0, 0, 1, 0, 8'd0), 2'd3, 32'h00FF0000, 32'h0, 8'd0, 8'd7},  // R7
    '{mkcfg(8'd2, 8'hFF, 1, 0, 0, 0, 0, 1, 0, 8'd0), 2'd2, 32'h00FF0000, 32'h0, 8'd8, 8'd7},  // R7
    '{mkcfg(8'd0, 8'h03, 1, 1, 0, 1, 0, 1, 0, 8'd0), 2'd0, 32'h00000003, 32'h1, 8'd3, 8'd8},  // R8
    '{mkcfg(8'd0, 8'h03, 1, 1, 0, 0, 0, 1, 0, 8'd0), 2'd0, 32'h00000003, 32'h1, 8'd2, 8'd8},  // R8
    '{mkcfg(8'd3, 8'hFF, 1, 1, 0, 0, 0, 1, 0, 8'd3), 2'd0, 32'h07000000, 32'h0, 8'd1, 8'd4},  // R4
    '{mkcfg(8'd3, 8'hFF, 1, 1, 0, 0, 0, 1, 0, 8'd4), 2'd0, 32'h07000000, 32'h0, 8'd0, 8'd4},  // R4
    '{mkcfg(8'd3, 8'hFF, 1, 1, 0, 0, 0, 1, 1, 8'd4), 2'd0, 32'h07000000, 32'h0, 8'd1, 8'd5},  // R5
    '{mkcfg(8'd3, 8'hFF, 1, 1, 0, 0, 0, 1, 1, 8'd3), 2'd0, 32'h07000000, 32'h0, 8'd0, 8'd5},  // R5
    '{mkcfg(8'd0, 8'hFF, 0, 0, 0, 0, 0, 1, 0, 8'd0), 2'd0, 32'h000000FF, 32'h0, 8'd0, 8'd7},  // R7
    '{mkcfg(8'd0, 8'hFF, 1, 1, 0, 0, 0, 0, 0, 8'd0), 2'd0, 32'h000000FF, 32'h0, 8'd0, 8'd9},  // R9
    '{mkcfg(8'd3, 8'hA5, 1, 1, 0, 0, 0, 1, 0, 8'd0), 2'd0, 32'hFF0000FF, 32'h0, 8'd4, 8'd2}   // R2
  };

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [31:0] c);
    loc_evt = '0; sib_evt = '0;
    cfg_we = 1'b1; cfg_wdata = c;
    cnt_we = 1'b1; cnt_wdata = '0;
    @(negedge clk);
    cfg_we = 1'b0; cnt_we = 1'b0;
  endtask

  task automatic setcnt(input logic [47:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnt", 64'(cnt_q), 64'd0);
    chk("R1 cfg", 64'(cfg_q), 64'd0);
    chk("R1 ovf", 64'(ovf_q), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i].cfg);
      priv_lvl = VEC[i].priv; loc_evt = VEC[i].loc; sib_evt = VEC[i].sib;
      @(negedge clk);
      loc_evt = '0; sib_evt = '0;
      chk($sformatf("R%0d vec%0d", VEC[i].req, i), 64'(cnt_q), 64'(VEC[i].exp));
    end
    priv_lvl = 2'd0;

    // R6 edge counting: two runs of the condition give two counts
    load(mkcfg(8'd0, 8'h01, 1, 1, 1, 0, 0, 1, 0, 8'd1));
    cyc(1);
    loc_evt = 32'h1; cyc(5);
    loc_evt = 32'h0; cyc(2);
    loc_evt = 32'h1; cyc(3);
    loc_evt = 32'h0; cyc(2);
    chk("R6 edge runs", 64'(cnt_q), 64'd2);

    // R9 disable holds and clears edge history
    load(mkcfg(8'd0, 8'h01, 1, 1, 1, 0, 0, 1, 0, 8'd1));
    cyc(1);
    loc_evt = 32'h1; cyc(3);
    chk("R9 pre", 64'(cnt_q), 64'd1);
    cfg_we = 1'b1; cfg_wdata = mkcfg(8'd0, 8'h01, 1, 1, 1, 0, 0, 0, 0, 8'd1);
    @(negedge clk); cfg_we = 1'b0;
    cyc(4);
    chk("R9 hold", 64'(cnt_q), 64'd1);
    cfg_we = 1'b1; cfg_wdata = mkcfg(8'd0, 8'h01, 1, 1, 1, 0, 0, 1, 0, 8'd1);
    @(negedge clk); cfg_we = 1'b0;
    cyc(3);
    chk("R9 reenable edge", 64'(cnt_q), 64'd2);
    loc_evt = '0;

    // R10 load wins over counting in the same cycle
    load(mkcfg(8'd0, 8'hFF, 1, 1, 0, 0, 0, 1, 0, 8'd0));
    loc_evt = 32'hFF; cnt_we = 1'b1; cnt_wdata = 48'd100;
    @(negedge clk); cnt_we = 1'b0;
    chk("R10 load priority", 64'(cnt_q), 64'd100);
    @(negedge clk); loc_evt = '0;
    chk("R10 count after load", 64'(cnt_q), 64'd108);

    // R11 carry without interrupt enable leaves flag clear
    setcnt(48'hFFFF_FFFF_FFFE);
    loc_evt = 32'h7; @(negedge clk); loc_evt = '0;
    chk("R11 wrap value", 64'(cnt_q), 64'd1);
    chk("R11 no ie flag", 64'(ovf_q), 64'd0);

    // R11 carry with interrupt enable sets sticky flag
    load(mkcfg(8'd0, 8'hFF, 1, 1, 0, 0, 1, 1, 0, 8'd0));
    setcnt(48'hFFFF_FFFF_FFFD);
    loc_evt = 32'h7; @(negedge clk); loc_evt = '0;
    chk("R11 wrap zero", 64'(cnt_q), 64'd0);
    chk("R11 ovf set", 64'(ovf_q), 64'd1);
    chk("R11 irq set", 64'(irq), 64'd1);
    cyc(3);
    chk("R11 sticky", 64'(irq), 64'd1);

    // R12 clear, then overflow coinciding with clear
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R12 cleared ovf", 64'(ovf_q), 64'd0);
    chk("R12 cleared irq", 64'(irq), 64'd0);
    setcnt(48'hFFFF_FFFF_FFFF);
    loc_evt = 32'h1; @(negedge clk); loc_evt = '0;
    chk("R12 reset flag", 64'(ovf_q), 64'd1);
    setcnt(48'hFFFF_FFFF_FFFF);
    loc_evt = 32'h1; ovf_clr = 1'b1;
    @(negedge clk); loc_evt = '0; ovf_clr = 1'b0;
    chk("R12 set wins", 64'(ovf_q), 64'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R12 clear alone", 64'(irq), 64'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule